// File: doc/BRIEF.md
# Peripheral Core Run-State Controller

This block owns the operational state of a serial peripheral core. Software drives it through a small 32-bit register window with a write strobe, a word address, write data and combinational read data. It keeps a two-bit state: held in reset, running or paused. It also keeps a ready flag, and software may only request a change while that flag is set. Each accepted state change pulls the ready flag low for a programmable number of clock cycles, which models the time the core needs to settle. Three one-hot outputs tell the attached datapath whether it is held, running or paused.

A transfer is normally driven as held, then run, then pause, then run again. The pause step is where the transmit buffer is preloaded. Leaving pause for the held state is guarded: software must write the clear code twice in a row. A separate soft-reset register forces the core back to the held state at any time.

Top module: `core_run_ctrl`

## Requirements
- R1: Once reset is released, the core is held (state 0), ready is 1, the ignored-write flag is 0, the clear-armed flag is 0 and the settle register reads its default of 4.
- R2: The status word at address 0 carries the state in bits [1:0] (0 held, 1 run, 3 pause), ready in bit 2, the ignored-write flag in bit 3 and the clear-armed flag in bit 4. All other bits read 0.
- R3: While ready is set and the core is held or running, a status write whose bits [1:0] are 0, 1 or 3 sets the state to that code. Code 2 there changes nothing and does not drop ready. The state never takes the value 2.
- R4: Each accepted state change clears ready for exactly N cycles, where N is the settle register's value, and then sets it again. When N is 0, ready never drops.
- R5: A status write that arrives while ready is 0 leaves the state untouched and sets the ignored-write flag, which then stays set.
- R6: In pause, a first write of code 2 only arms the clear: the state stays pause, bit 4 is set and ready stays high. A second consecutive status write of code 2 moves the core to held and starts a settle period.
- R7: In pause with the clear armed, any status write with a code other than 2 leaves the core in pause and disarms the clear.
- R8: In pause with the clear not armed, code 1 or 3 moves the core to that state, and code 0 leaves it in pause.
- R9: Writing address 1 with bit 0 set returns the core to held at once, whatever ready says. It also clears the armed and ignored-write flags and makes ready 1. A write there with bit 0 clear has no effect.
- R10: Exactly one of `core_held`, `core_run` and `core_paused` is high, and it matches the state.
- R11: The settle register at address 2 (bits [7:0]) can be written and read back, and its value sets the length of the following settle periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| core_held | output | 1 | Datapath held in reset |
| core_run | output | 1 | Datapath running |
| core_paused | output | 1 | Datapath paused |

## Verification
The bench targets the two-step exit from pause. A design that completed it on the first clear would fall to held early, and one that honoured an interrupting code would jump out of pause. It writes during the settle window: a design that accepted such a write would change state mid-settle, and one that dropped it silently would never raise the ignored-write flag. It counts the low-ready cycles for settle values of 0, 4 and 7, which exposes an off-by-one timer. It fires the soft reset during settle and while the clear is armed, which exposes leftover flags.

// File: rtl/crc_pkg.sv
// Package: shared encodings for the run-state controller.
// Assumes a word-addressed register window with three locations.
package crc_pkg;
    typedef enum logic [1:0] {
        CRC_ST_HELD  = 2'd0,
        CRC_ST_RUN   = 2'd1,
        CRC_ST_CLEAR = 2'd2,
        CRC_ST_PAUSE = 2'd3
    } crc_state_e;

    localparam int CRC_OFS_STATUS = 0;
    localparam int CRC_OFS_SOFTRST = 1;
    localparam int CRC_OFS_SETTLE = 2;

    localparam int CRC_BIT_READY = 2;
    localparam int CRC_BIT_IGNORED = 3;
    localparam int CRC_BIT_ARMED = 4;
endpackage

// File: rtl/crc_settle_timer.sv
// Settle timer: counts down after each accepted state change; ready is high
// only while the count is zero. Assumes load and clear are never both high.
module crc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic             ready
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: load on a new transition, clear on soft reset, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = (cnt_q == '0);

    // R4
    settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear && load_val != '0) |=> !ready);
    // R4
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !load) |=> ready);
endmodule

// File: rtl/crc_state_seq.sv
// State sequencer: holds the two-bit run state, the clear-armed flag and the
// ignored-write flag. Assumes st_wr and softrst come from one decoded write.
module crc_state_seq
    import crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic [1:0] code,
    input  logic       ready,
    input  logic       softrst,
    output crc_state_e state,
    output logic       armed,
    output logic       ignored,
    output logic       start
);
    crc_state_e state_q, state_d, code_e;
    logic       armed_q, armed_d, ignored_q, accept;

    assign code_e = crc_state_e'(code);
    assign accept = st_wr && ready && !softrst;

    // Next-state rule for an accepted status write.
    always_comb begin
        state_d = state_q;
        armed_d = armed_q;
        start   = 1'b0;
        if (accept) begin
            if (state_q == CRC_ST_PAUSE) begin
                if (armed_q) begin
                    armed_d = 1'b0;
                    if (code_e == CRC_ST_CLEAR) begin
                        state_d = CRC_ST_HELD;
                        start   = 1'b1;
                    end
                end else if (code_e == CRC_ST_CLEAR) begin
                    armed_d = 1'b1;
                end else if (code_e != CRC_ST_HELD) begin
                    state_d = code_e;
                    start   = 1'b1;
                end
            end else if (code_e != CRC_ST_CLEAR) begin
                state_d = code_e;
                start   = 1'b1;
            end
        end
    end

    // State and flag registers; soft reset takes priority over any write.
    always_ff @(posedge clk) begin
        if (!rst_n || softrst) begin
            state_q   <= CRC_ST_HELD;
            armed_q   <= 1'b0;
            ignored_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
            if (st_wr && !ready) begin
                ignored_q <= 1'b1;
            end
        end
    end

    assign state   = state_q;
    assign armed   = armed_q;
    assign ignored = ignored_q;

    // R3
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != CRC_ST_CLEAR);
    // R5
    late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !ready && !softrst) |=> ($stable(state_q) && ignored_q));
    // R6
    first_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == CRC_ST_PAUSE && !armed_q && code_e == CRC_ST_CLEAR)
        |=> (state_q == CRC_ST_PAUSE && armed_q));
    // R7
    broken_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == CRC_ST_PAUSE && armed_q && code_e != CRC_ST_CLEAR)
        |=> (state_q == CRC_ST_PAUSE && !armed_q));
    // R9
    softrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        softrst |=> (state_q == CRC_ST_HELD && !armed_q && !ignored_q));
endmodule

// File: rtl/crc_reg_view.sv
// Read view: combinational read mux over the status, soft-reset and settle
// locations. Assumes reads have no side effects.
module crc_reg_view
    import crc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  crc_state_e        state,
    input  logic              ready,
    input  logic              ignored,
    input  logic              armed,
    input  logic [CNT_W-1:0]  settle,
    output logic [31:0]       rdata
);
    // Select the word addressed by the bus.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CRC_OFS_STATUS)) begin
            rdata[1:0]             = state;
            rdata[CRC_BIT_READY]   = ready;
            rdata[CRC_BIT_IGNORED] = ignored;
            rdata[CRC_BIT_ARMED]   = armed;
        end else if (addr == ADDR_W'(CRC_OFS_SETTLE)) begin
            rdata[CNT_W-1:0] = settle;
        end
    end
endmodule

// File: rtl/core_run_ctrl.sv
// Top: decodes register writes, keeps the settle setting and drives the
// datapath state outputs. Assumes single-cycle register writes.
module core_run_ctrl
    import crc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 8,
    parameter int SETTLE_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              core_held,
    output logic              core_run,
    output logic              core_paused
);
    logic             st_wr, softrst, settle_wr, ready, armed, ignored, start;
    logic [CNT_W-1:0] settle_q;
    crc_state_e       state;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[31:CNT_W];
    assign st_wr     = reg_wr && (reg_addr == ADDR_W'(CRC_OFS_STATUS));
    assign softrst   = reg_wr && (reg_addr == ADDR_W'(CRC_OFS_SOFTRST)) && reg_wdata[0];
    assign settle_wr = reg_wr && (reg_addr == ADDR_W'(CRC_OFS_SETTLE));

    // Settle setting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= CNT_W'(SETTLE_INIT);
        end else if (settle_wr) begin
            settle_q <= reg_wdata[CNT_W-1:0];
        end
    end

    crc_state_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_wr   (st_wr),
        .code    (reg_wdata[1:0]),
        .ready   (ready),
        .softrst (softrst),
        .state   (state),
        .armed   (armed),
        .ignored (ignored),
        .start   (start)
    );

    crc_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .clear    (softrst),
        .load_val (settle_q),
        .ready    (ready)
    );

    crc_reg_view #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_view (
        .addr    (reg_addr),
        .state   (state),
        .ready   (ready),
        .ignored (ignored),
        .armed   (armed),
        .settle  (settle_q),
        .rdata   (reg_rdata)
    );

    assign core_held   = (state == CRC_ST_HELD);
    assign core_run    = (state == CRC_ST_RUN);
    assign core_paused = (state == CRC_ST_PAUSE);

    // R10
    one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({core_held, core_run, core_paused}) == 1);
    // R9
    softrst_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        softrst |=> (core_held && reg_rdata[CRC_BIT_READY] == 1'b1) || reg_addr != '0);
endmodule

// File: tb/core_run_ctrl_bench.sv
`timescale 1ns/1ps
module core_run_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_held, core_run, core_paused;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // reference model state
    logic [1:0] m_state;
    logic       m_arm, m_ign;
    logic [7:0] m_cnt, m_settle;

    always #2.5 clk = ~clk;

    core_run_ctrl u_core_run_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_held(core_held),
        .core_run(core_run), .core_paused(core_paused)
    );

    function automatic logic [31:0] exp_status();
        return {27'd0, m_arm, m_ign, (m_cnt == 8'd0), m_state};
    endfunction

    // Model of the register rules, applied to the pre-edge model state.
    function automatic void model_step(logic wr, logic [3:0] a, logic [31:0] d);
        logic rdy;
        rdy = (m_cnt == 8'd0);
        if (m_cnt != 8'd0) m_cnt = m_cnt - 8'd1;
        if (!wr) return;
        if (a == 4'd1 && d[0]) begin
            m_state = 2'd0; m_arm = 1'b0; m_ign = 1'b0; m_cnt = 8'd0;
        end else if (a == 4'd2) begin
            m_settle = d[7:0];
        end else if (a == 4'd0) begin
            if (!rdy) m_ign = 1'b1;
            else if (m_state == 2'd3) begin
                if (m_arm) begin
                    m_arm = 1'b0;
                    if (d[1:0] == 2'd2) begin m_state = 2'd0; m_cnt = m_settle; end
                end else if (d[1:0] == 2'd2) m_arm = 1'b1;
                else if (d[1:0] != 2'd0) begin m_state = d[1:0]; m_cnt = m_settle; end
            end else if (d[1:0] != 2'd2) begin
                m_state = d[1:0]; m_cnt = m_settle;
            end
        end
    endfunction

    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        model_step(wr, a, d);
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = '0;
    endtask

    task automatic check(input string tag);
        logic [34:0] act, exp;
        #0.5;
        act = {core_held, core_run, core_paused, reg_rdata};
        exp = {m_state == 2'd0, m_state == 2'd1, m_state == 2'd3, exp_status()};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_settle(input string tag);
        reg_addr = 4'd2;
        #0.5;
        n_checks++;
        if (reg_rdata !== {24'd0, m_settle}) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, reg_rdata, {24'd0, m_settle});
        end
        reg_addr = 4'd0;
    endtask

    task automatic idle_until_ready(input string tag);
        for (int i = 0; i < 300 && m_cnt != 8'd0; i++) begin
            step(1'b0, 4'd0, 32'd0);
            check(tag);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_v;
        m_state = 2'd0; m_arm = 1'b0; m_ign = 1'b0; m_cnt = 8'd0; m_settle = 8'd4;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset status");
        check_settle("R1 settle default");

        // R3 / R4: held -> run, ready low for exactly 4 cycles
        step(1'b1, 4'd0, 32'd1);
        for (int i = 0; i < 5; i++) begin step(1'b0, 4'd0, 32'd0); check("R4 settle count"); end
        // R5: write while ready low
        step(1'b1, 4'd0, 32'd3);
        check("R5 accepted start");
        step(1'b1, 4'd0, 32'd0);
        check("R5 ignored write");
        idle_until_ready("R5 drain");
        // R9: soft reset clears sticky; bit0 clear has no effect
        step(1'b1, 4'd1, 32'd0);
        check("R9 softrst bit0 low");
        step(1'b1, 4'd1, 32'd1);
        check("R9 softrst");
        // R3: code 2 from run does nothing
        step(1'b1, 4'd0, 32'd1); idle_until_ready("R3 to run");
        step(1'b1, 4'd0, 32'd2);
        check("R3 code2 in run");
        // R6: pause then double clear
        step(1'b1, 4'd0, 32'd3); idle_until_ready("R6 to pause");
        step(1'b1, 4'd0, 32'd2);
        check("R6 first clear arms");
        step(1'b1, 4'd0, 32'd2);
        check("R6 second clear");
        idle_until_ready("R6 drain");
        // R7: armed clear broken by another code
        step(1'b1, 4'd0, 32'd3); idle_until_ready("R7 to pause");
        step(1'b1, 4'd0, 32'd2);
        step(1'b1, 4'd0, 32'd1);
        check("R7 broken clear");
        // R8: unarmed pause, code 0 stays
        step(1'b1, 4'd0, 32'd0);
        check("R8 code0 in pause");
        step(1'b1, 4'd0, 32'd1);
        check("R8 pause to run");
        idle_until_ready("R8 drain");
        // R9 while armed
        step(1'b1, 4'd0, 32'd3); idle_until_ready("R9 to pause");
        step(1'b1, 4'd0, 32'd2);
        step(1'b1, 4'd1, 32'h1);
        check("R9 softrst while armed");
        // R11 / R4: settle 0 and settle 7
        step(1'b1, 4'd2, 32'd0);
        check_settle("R11 settle write 0");
        step(1'b1, 4'd0, 32'd1);
        check("R4 settle zero no drop");
        step(1'b1, 4'd2, 32'h0000_0107);
        check_settle("R11 settle write 7");
        step(1'b1, 4'd0, 32'd3);
        for (int i = 0; i < 8; i++) begin step(1'b0, 4'd0, 32'd0); check("R11 settle 7 count"); end

        // R2 / R10 random phase
        seed_v = $urandom(32'd1234);
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [3:0] a;
            logic [31:0] d;
            r = $urandom_range(0, 99);
            if (r < 55) a = 4'd0;
            else if (r < 58) a = 4'd1;
            else if (r < 63) a = 4'd2;
            else a = 4'($urandom_range(3, 15));
            d = $urandom();
            if (a == 4'd2) d[7:0] = 8'($urandom_range(0, 6));
            step($urandom_range(0, 2) != 0, a, d);
            check("R2 random status");
            if (i % 97 == 0) check_settle("R11 random settle");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule